// File: doc/BRIEF.md
# Reloadable Down-Counter Timer with APB Register Access

This block is a programmable down-counter that sits on an APB slave port inside a 4 KB address window. Software loads a start value, chooses how the counter advances, and can enable an interrupt. The counter can step once per bus clock. It can also step only while an external pin is high, or once per rising edge of that pin. Both external modes sample the pin through a two-flop synchroniser.

When the count steps from one to zero, the block can latch a pending flag. That flag drives a level interrupt until software clears it. After reaching zero, the counter holds there for one counting step and then restarts from the reload value. If the reload value is zero, the counter stays at zero and raises no further interrupts. A small read-only identification table sits at the top of the window.

Top module: `apb_dcnt_timer`

## Requirements
- R1: After a synchronous reset, the control, count, reload and pending state all read as zero, and `irq` is low.
- R2: The control word sits at offset 0x000. Bit 0 is run, bit 1 is gate mode, bit 2 is edge mode and bit 3 is interrupt enable. Only these four bits are stored, and bits 31:4 read as zero. When bits 1 and 2 are both set, edge mode applies.
- R3: The status word sits at offset 0x00C, and its bit 0 is the pending flag. Writing 1 to bit 0 clears the flag. Writing 0 leaves it unchanged. If a set and a clear happen in the same cycle, the set wins.
- R4: The pending flag is set only when a counting step takes the count from 1 to 0 while bit 3 of the control word is set. `irq` always equals the pending flag.
- R5: A counting step taken at count 0 loads the reload value, so the count dwells at zero for one step. With a reload value of 0, the count stays at 0 and no further interrupt occurs.
- R6: The count is readable and writable at offset 0x004. A write replaces the count, and it takes priority over a counting step in the same cycle.
- R7: The reload value sits at offset 0x008. A write to it also loads the written value into the count.
- R8: With run set and neither external mode selected, the counter takes one counting step per clock cycle.
- R9: In gate mode, a counting step occurs only in cycles where the synchronised pin is high. A pin level sampled at clock edge n gates the step taken at edge n+2.
- R10: In edge mode, exactly one counting step occurs per rising edge of the synchronised pin, as a one-cycle strobe.
- R11: The twelve words at 0xFD0 to 0xFFC hold, in address order, the bytes 03, 00, 00, 00, 6A, C4, 1E, 00, 3C, A5, 5A, C3 in bits 7:0. Writes to these words are ignored.
- R12: Reads of any other offset return 0, and writes to them change nothing. `pready` is always 1 and `pslverr` is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 12 | Byte offset in the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always high, so there are no wait states |
| pslverr | output | 1 | Always low |
| ext_in | input | 1 | Asynchronous external count enable or count clock |
| irq | output | 1 | Level interrupt that follows the pending flag |

## Verification
The counter is first run in bus-clock mode with reload values of 5, 3 and 0. These runs separate a correct 1-to-0 interrupt and one-step zero dwell from an early reload or an interrupt raised on reload. Gate mode is driven with an irregular 3-high/4-low pin pattern, which exposes a wrong synchroniser depth or an inverted gate. Edge mode uses a 3/3 square wave, which separates one step per rising edge from level counting. The same wave with both mode bits set confirms that edge mode has priority. Register-level runs with the interrupt disabled, status writes of 0, ID-table writes and unmapped accesses show that these leave the observable state unchanged.

// File: rtl/apb_dcnt_pkg.sv
package apb_dcnt_pkg;

    localparam int unsigned BUS_W  = 32;
    localparam int unsigned ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_CTRL    = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_COUNT   = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_RELOAD  = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_STATUS  = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_ID_BASE = 12'hFD0;

    // Control word, bit 3 down to bit 0
    typedef struct packed {
        logic irq_en;
        logic ext_clk;
        logic ext_gate;
        logic run;
    } ctrl_t;

    // One-hot write strobes for the writable words
    typedef struct packed {
        logic ctrl;
        logic count;
        logic reload;
        logic status;
    } wsel_t;

    typedef enum logic [1:0] {
        SRC_PCLK = 2'd0,
        SRC_GATE = 2'd1,
        SRC_EDGE = 2'd2
    } tsrc_e;

    // Edge mode has priority over gate mode
    function automatic tsrc_e pick_src(ctrl_t c);
        if (c.ext_clk)       return SRC_EDGE;
        else if (c.ext_gate) return SRC_GATE;
        else                 return SRC_PCLK;
    endfunction

    // Identification byte for a byte offset measured from OFS_ID_BASE
    function automatic logic [7:0] id_byte(logic [ADDR_W-1:0] off);
        case (off)
            12'h000: return 8'h03;
            12'h010: return 8'h6A;
            12'h014: return 8'hC4;
            12'h018: return 8'h1E;
            12'h020: return 8'h3C;
            12'h024: return 8'hA5;
            12'h028: return 8'h5A;
            12'h02C: return 8'hC3;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/apb_dcnt_sync.sv
module apb_dcnt_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic lvl,
    output logic rise
);
    // chain[STAGES-1] is the synchronised level, chain[STAGES] its delayed copy
    logic [STAGES:0] chain;

    for (genvar i = 0; i <= STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    assign lvl  = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~chain[STAGES];

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);  // R10

endmodule

// File: rtl/apb_dcnt_core.sv
module apb_dcnt_core
    import apb_dcnt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic             ext_lvl,
    input  logic             ext_rise,
    input  wsel_t            wsel,
    input  logic [CNT_W-1:0] wval,
    input  logic [CNT_W-1:0] reload,
    input  logic             clr_req,
    output logic [CNT_W-1:0] cnt,
    output logic             pending
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic tick;
    logic load;
    logic hit_zero;

    always_comb begin
        case (pick_src(ctrl))
            SRC_EDGE: tick = ctrl.run & ext_rise;
            SRC_GATE: tick = ctrl.run & ext_lvl;
            default:  tick = ctrl.run;
        endcase
    end

    assign load     = wsel.count | wsel.reload;
    assign hit_zero = tick & ~load & (cnt == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= wval;
        end else if (tick) begin
            cnt <= (cnt == '0) ? reload : cnt - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else if (hit_zero & ctrl.irq_en) begin
            pending <= 1'b1;
        end else if (clr_req) begin
            pending <= 1'b0;
        end
    end

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && cnt > ONE) |=> cnt == $past(cnt) - ONE);  // R8

    AST_DWELL_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && cnt == '0) |=> cnt == $past(reload));  // R5

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(cnt));  // R9

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt == $past(wval));  // R6

    AST_PEND_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $rose(pending) |-> ($past(cnt) == ONE && cnt == '0 && $past(ctrl.irq_en)));  // R4

    AST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr_req && cnt != ONE) |=> !pending);  // R3

endmodule

// File: rtl/apb_dcnt_regs.sv
module apb_dcnt_regs
    import apb_dcnt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [BUS_W-1:0]  pwdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              pending,
    output logic [BUS_W-1:0]  prdata,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  reload,
    output wsel_t             wsel,
    output logic [CNT_W-1:0]  wval,
    output logic              clr_req
);
    logic              wr;
    logic              is_id;
    logic [ADDR_W-1:0] id_off;

    assign wr     = psel & penable & pwrite;
    assign is_id  = (paddr >= OFS_ID_BASE) && (paddr[1:0] == 2'b00);
    assign id_off = paddr - OFS_ID_BASE;

    assign wsel.ctrl   = wr && (paddr == OFS_CTRL);
    assign wsel.count  = wr && (paddr == OFS_COUNT);
    assign wsel.reload = wr && (paddr == OFS_RELOAD);
    assign wsel.status = wr && (paddr == OFS_STATUS);

    assign wval    = pwdata[CNT_W-1:0];
    assign clr_req = wsel.status & pwdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            reload <= '0;
        end else begin
            if (wsel.ctrl)   ctrl   <= ctrl_t'(pwdata[3:0]);
            if (wsel.reload) reload <= pwdata[CNT_W-1:0];
        end
    end

    always_comb begin
        prdata = '0;
        if (psel) begin
            case (paddr)
                OFS_CTRL:   prdata = BUS_W'(ctrl);
                OFS_COUNT:  prdata = BUS_W'(cnt);
                OFS_RELOAD: prdata = BUS_W'(reload);
                OFS_STATUS: prdata = BUS_W'(pending);
                default:    prdata = is_id ? BUS_W'(id_byte(id_off)) : '0;
            endcase
        end
    end

    AST_RELOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        wsel.reload |=> reload == $past(pwdata[CNT_W-1:0]));  // R7

    AST_CTRL_KEEP: assert property (@(posedge clk) disable iff (rst)
        !wsel.ctrl |=> $stable(ctrl));  // R12

endmodule

// File: rtl/apb_dcnt_timer.sv
module apb_dcnt_timer
    import apb_dcnt_pkg::*;
#(
    parameter int unsigned CNT_W       = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [BUS_W-1:0]  pwdata,
    output logic [BUS_W-1:0]  prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              ext_in,
    output logic              irq
);
    ctrl_t            ctrl;
    wsel_t            wsel;
    logic [CNT_W-1:0] wval;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] cnt;
    logic             clr_req;
    logic             pending;
    logic             ext_lvl;
    logic             ext_rise;

    apb_dcnt_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst      (rst),
        .async_in (ext_in),
        .lvl      (ext_lvl),
        .rise     (ext_rise)
    );

    apb_dcnt_regs #(.CNT_W(CNT_W)) regs_i (
        .clk     (clk),
        .rst     (rst),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .cnt     (cnt),
        .pending (pending),
        .prdata  (prdata),
        .ctrl    (ctrl),
        .reload  (reload),
        .wsel    (wsel),
        .wval    (wval),
        .clr_req (clr_req)
    );

    apb_dcnt_core #(.CNT_W(CNT_W)) core_i (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl),
        .ext_lvl  (ext_lvl),
        .ext_rise (ext_rise),
        .wsel     (wsel),
        .wval     (wval),
        .reload   (reload),
        .clr_req  (clr_req),
        .cnt      (cnt),
        .pending  (pending)
    );

    assign pready  = 1'b1;
    assign pslverr = 1'b0;
    assign irq     = pending;

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq && !(psel && penable && pwrite && paddr == OFS_STATUS)) |=> irq);  // R4

endmodule

// File: tb/apb_dcnt_timer_tb_top.sv
`timescale 1ns/1ps
module apb_dcnt_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        pslverr;
    logic        ext_in = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] id_tab [12] = '{8'h03, 8'h00, 8'h00, 8'h00, 8'h6A, 8'hC4,
                                8'h1E, 8'h00, 8'h3C, 8'hA5, 8'h5A, 8'hC3};

    // Reference model state
    logic [31:0] m_cnt, m_rel;
    logic [3:0]  m_ctrl;
    logic        m_pend, s1, s2, s3;

    always #2.5 clk = ~clk;

    apb_dcnt_timer dut_i (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .ext_in(ext_in), .irq(irq)
    );

    always @(posedge clk) begin : model
        logic wr, tk, setp;
        if (rst) begin
            m_cnt = 0; m_rel = 0; m_ctrl = 0; m_pend = 0;
            s1 = 0; s2 = 0; s3 = 0;
        end else begin
            wr = psel && penable && pwrite;
            if (m_ctrl[2])      tk = s2 && !s3;
            else if (m_ctrl[1]) tk = s2;
            else                tk = 1'b1;
            tk = tk && m_ctrl[0];
            setp = 1'b0;
            if (wr && paddr == 12'h004) begin
                m_cnt = pwdata;
            end else if (wr && paddr == 12'h008) begin
                m_rel = pwdata;
                m_cnt = pwdata;
            end else if (tk) begin
                if (m_cnt == 0) begin
                    m_cnt = m_rel;
                end else begin
                    if (m_cnt == 1 && m_ctrl[3]) setp = 1'b1;
                    m_cnt = m_cnt - 1;
                end
            end
            if (wr && paddr == 12'h000) m_ctrl = pwdata[3:0];
            if (setp) m_pend = 1'b1;
            else if (wr && paddr == 12'h00C && pwdata[0]) m_pend = 1'b0;
            s3 = s2; s2 = s1; s1 = ext_in;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [11:0] a);
        case (a)
            12'h000: return {28'b0, m_ctrl};
            12'h004: return m_cnt;
            12'h008: return m_rel;
            12'h00C: return {31'b0, m_pend};
            default: begin
                if (a >= 12'hFD0 && a[1:0] == 2'b00) return {24'b0, id_tab[(a - 12'hFD0) >> 2]};
                return 32'h0;
            end
        endcase
    endfunction

    // irq compared to the model on every cycle
    always @(negedge clk) begin
        if (!rst && !done) chk("R4 irq", {31'b0, irq}, {31'b0, m_pend});
    end

    task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [11:0] a, input string req);
        @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge clk); penable = 1;
        chk(req, prdata, exp_rd(a));
        chk("R12 ready", {30'b0, pready, pslverr}, 32'h2);
        @(negedge clk); psel = 0; penable = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        apb_rd(12'h000, "R1 ctrl");
        apb_rd(12'h004, "R1 count");
        apb_rd(12'h008, "R1 reload");
        apb_rd(12'h00C, "R1 status");
        // R2 upper bits masked
        apb_wr(12'h000, 32'hFFFF_FFF0);
        apb_rd(12'h000, "R2 mask");
        // R7 reload also loads count
        apb_wr(12'h008, 32'd5);
        apb_rd(12'h004, "R7 count");
        apb_rd(12'h008, "R7 reload");
        // R8 bus clock counting with interrupt, R5 dwell
        apb_wr(12'h000, 32'h9);
        apb_rd(12'h000, "R2 ctrl");
        for (int i = 0; i < 10; i++) apb_rd(12'h004, "R8 R5 count");
        // R3 clear behaviour
        apb_wr(12'h000, 32'h0);
        apb_rd(12'h00C, "R3 pending");
        apb_wr(12'h00C, 32'h0);
        apb_rd(12'h00C, "R3 write0");
        apb_wr(12'h00C, 32'h1);
        apb_rd(12'h00C, "R3 write1");
        // R5 zero reload: stuck at zero, no interrupt
        apb_wr(12'h008, 32'd0);
        apb_wr(12'h000, 32'h9);
        repeat (20) @(negedge clk);
        apb_rd(12'h004, "R5 zero");
        apb_rd(12'h00C, "R5 nopend");
        // R4 interrupt disabled
        apb_wr(12'h000, 32'h1);
        apb_wr(12'h008, 32'd3);
        repeat (20) @(negedge clk);
        apb_rd(12'h00C, "R4 disabled");
        // R6 direct count write
        apb_wr(12'h000, 32'h0);
        apb_wr(12'h004, 32'd100);
        apb_rd(12'h004, "R6 write");
        apb_rd(12'h008, "R6 reload kept");
        apb_wr(12'h000, 32'h1);
        apb_wr(12'h004, 32'd40);
        apb_rd(12'h004, "R6 running");
        // R9 gate mode
        apb_wr(12'h008, 32'd4);
        apb_wr(12'h000, 32'hB);
        fork
            begin
                for (int i = 0; i < 60; i++) begin
                    @(negedge clk); ext_in = (i % 7) < 3;
                end
            end
            begin
                for (int i = 0; i < 12; i++) apb_rd(12'h004, "R9 gate");
            end
        join
        apb_wr(12'h00C, 32'h1);
        // R10 edge mode
        apb_wr(12'h008, 32'd3);
        apb_wr(12'h000, 32'hD);
        fork
            begin
                for (int i = 0; i < 80; i++) begin
                    @(negedge clk); ext_in = (i % 6) < 3;
                end
            end
            begin
                for (int i = 0; i < 20; i++) apb_rd(12'h004, "R10 edge");
            end
        join
        // R2 both modes: edge wins
        apb_wr(12'h008, 32'd2);
        apb_wr(12'h000, 32'hF);
        fork
            begin
                for (int i = 0; i < 48; i++) begin
                    @(negedge clk); ext_in = (i % 6) < 3;
                end
            end
            begin
                for (int i = 0; i < 12; i++) apb_rd(12'h004, "R2 priority");
            end
        join
        apb_wr(12'h000, 32'h0);
        apb_wr(12'h00C, 32'h1);
        // R11 ID table
        for (int k = 0; k < 12; k++) apb_rd(12'hFD0 + 12'(4 * k), "R11 id");
        apb_wr(12'hFD0, 32'hFF);
        apb_wr(12'hFFC, 32'h0);
        apb_rd(12'hFD0, "R11 ro");
        apb_rd(12'hFFC, "R11 ro");
        // R12 unmapped
        apb_wr(12'h010, 32'hFFFF_FFFF);
        apb_rd(12'h010, "R12 unmapped");
        apb_rd(12'h800, "R12 unmapped");
        apb_rd(12'h000, "R12 ctrl kept");
        apb_rd(12'h004, "R12 count kept");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule